// File: doc/BRIEF.md
# Stereo Bi-Phase Digital Audio Transmitter

This block produces a two-channel serial digital audio stream of the AES3 / S/PDIF kind from parallel samples. Left and right samples arrive with a strobe. Each one waits in a one-entry holding register until the next frame picks it up. Every frame carries an A (left) subframe and a B (right) subframe. Each subframe has a preamble, 24 audio bits, a validity bit, a user bit, a channel-status bit and a parity bit. The stream is bi-phase mark encoded and driven as a complementary pair, `txP` and `txN`. The channel-status bits come from a 192-bit vector for each channel, indexed by the frame number within a 192-frame block. The user bits come from a similar vector for each channel, or from a serial pin when `userExtSel` is set.

The cell timing comes from `cellEn`. Each pulse of `cellEn` emits one half-bit cell, so one frame takes 128 cells. The block-sync pin has two roles. In input mode, a long enough high level on `syncIn` restarts the transmitter at the first frame of a new block. In output mode, `syncOut` marks the first frame of each block. When the sample source runs asynchronously to the transmit timing, `slipPulse` reports every sample that is lost or sent twice. `mute` blanks the audio payload. `outDisable` or a missing transmit clock parks both line outputs low.

Top module: `aes3Tx`

## Requirements
- R1: Each subframe has 32 slots of two cells each. Slots 0-3 hold the preamble, slots 4-27 the audio sample LSB first, slot 28 the validity bit, slot 29 the user bit, slot 30 the channel-status bit and slot 31 a parity bit that makes slots 4-31 carry an even number of ones.
- R2: In slots 4-31, `txP` changes at the start of every slot and changes again between its two cells only when the slot's bit is 1. `txN` is the complement of `txP` while the outputs are enabled.
- R3: The eight preamble cells follow 11101000 for the A subframe of frame 0, 11100010 for the other A subframes and 11100100 for B subframes. The pattern is inverted when the line was high before the subframe.
- R4: The channel-status bit of frame f is bit f of `csLeft` in the A subframe and bit f of `csRight` in the B subframe. A block has 192 frames, numbered 0-191, and then wraps to 0.
- R5: The user bit of frame f is bit f of `userLeft` or `userRight`. When `userExtSel` is 1, it is instead the value of `userPin` at the first cell of the subframe.
- R6: While `mute` is 1, the audio slots are sent as zeros. Preambles, V, U and C are unchanged, and parity is computed over the bits actually sent.
- R7: `txP` and `txN` are both 0 while `rstN` is 0, while `txClkOk` is 0, or while `outDisable` is 1.
- R8: Each frame sends the sample most recently strobed before its first cell. If no sample has been strobed since the previous frame started, the previous values are sent again (zero after reset).
- R9: `slipPulse` is high for one clock for each strobed sample that is overwritten before it is sent, and for each frame that has to resend old values.
- R10: With `syncIsInput` at 1, `syncIn` held high for four or more consecutive clocks restarts transmission at cell 0 of frame 0. Three clocks or fewer have no effect.
- R11: A single continuous high level on `syncIn` causes only one restart, however long it lasts.
- R12: With `syncIsInput` at 0, `syncOe` is 1 and `syncOut` is high during frame 0 of each block and low during the other frames. With `syncIsInput` at 1, `syncOe` and `syncOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellEn | input | 1 | One pulse per half-bit cell |
| txClkOk | input | 1 | Transmit clock present |
| sampleStrobe | input | 1 | Loads leftIn/rightIn into the holding registers |
| leftIn | input | 24 | Left (A) sample |
| rightIn | input | 24 | Right (B) sample |
| validIn | input | 1 | Validity bit for the subframes |
| csLeft | input | 192 | Channel-status block, A channel |
| csRight | input | 192 | Channel-status block, B channel |
| userLeft | input | 192 | Internal user bits, A channel |
| userRight | input | 192 | Internal user bits, B channel |
| userExtSel | input | 1 | Take user bits from userPin |
| userPin | input | 1 | Serial user-bit input |
| mute | input | 1 | Zero the audio payload |
| outDisable | input | 1 | Force both line outputs low |
| syncIsInput | input | 1 | 1: sync pin is an input, 0: it is an output |
| syncIn | input | 1 | Block-sync input (asynchronous) |
| syncOut | output | 1 | Block-start indication |
| syncOe | output | 1 | Output enable for the sync pin |
| txP | output | 1 | Encoded line, true |
| txN | output | 1 | Encoded line, complement |
| slipPulse | output | 1 | Sample dropped or repeated |

## Verification
A wrong cell or frame counter changes the preamble shape or the channel-status bit taken from the vectors. The error shows within one subframe, 64 cells, and a wrong block wrap shows at frame 192. A bad payload register or parity bit breaks the transition pattern inside the data slots of the affected subframe. A fault in the holding register appears as a wrong sample one frame later, or as a `slipPulse` count that differs from the number of drops and repeats. A sync qualifier that fires too early, too late or twice shows as a B preamble at the wrong place in the cell stream.

// File: rtl/aes3TxPkg.sv
package aes3TxPkg;
  parameter int BLOCK_FRAMES = 192;
  parameter int SAMPLE_W = 24;
  localparam int FRAME_W = $clog2(BLOCK_FRAMES);
  localparam int SUB_SLOTS = 32;
  localparam int SUB_CELLS = 2 * SUB_SLOTS;
  localparam int CELL_W = $clog2(2 * SUB_CELLS);
  localparam int SUBCELL_W = $clog2(SUB_CELLS);
  localparam int PAY_W = SUB_SLOTS - 4;

  localparam logic [7:0] PRE_B = 8'b11101000;
  localparam logic [7:0] PRE_M = 8'b11100010;
  localparam logic [7:0] PRE_W = 8'b11100100;

  typedef struct packed {
    logic                 emit;
    logic                 subStart;
    logic                 frameStart;
    logic                 chanB;
    logic [FRAME_W-1:0]   frameIdx;
    logic [SUBCELL_W-1:0] subCell;
  } txStrobe_t;
endpackage

// File: rtl/aes3TxCtrl.sv
module aes3TxCtrl
  import aes3TxPkg::*;
#(
  parameter int SYNC_HOLD = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cellEn,
  input  logic      syncIsInput,
  input  logic      syncIn,
  output txStrobe_t strobe,
  output logic      syncOut
);
  localparam int HOLD_W = $clog2(SYNC_HOLD + 1);

  logic [CELL_W-1:0]  cellIdx;
  logic [FRAME_W-1:0] frameIdx;
  logic [1:0]         syncMeta;
  logic               syncLvl;
  logic [HOLD_W-1:0]  hiCnt;
  logic               armed;
  logic               forceStart;
  logic               emit;
  logic               blockFlag;

  assign syncLvl    = syncMeta[1];
  assign forceStart = syncLvl && armed && (hiCnt == HOLD_W'(SYNC_HOLD));
  assign emit       = cellEn && !forceStart;

  // sync qualifier: count consecutive high clocks, fire once per high level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMeta <= '0;
      hiCnt    <= '0;
      armed    <= 1'b1;
    end else begin
      syncMeta <= {syncMeta[0], syncIn & syncIsInput};
      if (!syncLvl) hiCnt <= '0;
      else if (hiCnt != HOLD_W'(SYNC_HOLD)) hiCnt <= hiCnt + 1'b1;
      if (!syncLvl) armed <= 1'b1;
      else if (forceStart) armed <= 1'b0;
    end
  end

  // cell and frame position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellIdx  <= '0;
      frameIdx <= '0;
    end else if (forceStart) begin
      cellIdx  <= '0;
      frameIdx <= '0;
    end else if (emit) begin
      cellIdx <= cellIdx + 1'b1;
      if (cellIdx == CELL_W'(2 * SUB_CELLS - 1))
        frameIdx <= (frameIdx == FRAME_W'(BLOCK_FRAMES - 1)) ? '0 : frameIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) blockFlag <= 1'b0;
    else if (emit && cellIdx == '0) blockFlag <= (frameIdx == '0);
  end

  assign syncOut = blockFlag && !syncIsInput;

  always_comb begin
    strobe.emit       = emit;
    strobe.subStart   = emit && (cellIdx[SUBCELL_W-1:0] == '0);
    strobe.frameStart = emit && (cellIdx == '0);
    strobe.chanB      = cellIdx[CELL_W-1];
    strobe.frameIdx   = frameIdx;
    strobe.subCell    = cellIdx[SUBCELL_W-1:0];
  end
endmodule

// File: rtl/aes3TxPath.sv
module aes3TxPath
  import aes3TxPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  txStrobe_t               strobe,
  input  logic                    sampleStrobe,
  input  logic [SAMPLE_W-1:0]     leftIn,
  input  logic [SAMPLE_W-1:0]     rightIn,
  input  logic                    validIn,
  input  logic [BLOCK_FRAMES-1:0] csLeft,
  input  logic [BLOCK_FRAMES-1:0] csRight,
  input  logic [BLOCK_FRAMES-1:0] userLeft,
  input  logic [BLOCK_FRAMES-1:0] userRight,
  input  logic                    userExtSel,
  input  logic                    userPin,
  input  logic                    mute,
  output logic                    lineLvl,
  output logic                    slipPulse
);
  logic [SAMPLE_W-1:0] holdL, holdR, txL, txR;
  logic                fresh;
  logic [SAMPLE_W-1:0] useL, audio;
  logic                cBit, uBit, parBit;
  logic [PAY_W-1:0]    newPay, payload;
  logic [7:0]          newPat, patReg, patNow;
  logic                startLvl, startNow;
  logic                dropEvt, repeatEvt;
  logic [4:0]          slotIdx;
  logic [4:0]          payIdx;
  logic                nextLvl;

  assign useL = fresh ? holdL : txL;

  always_comb begin
    audio  = strobe.chanB ? txR : useL;
    if (mute) audio = '0;
    cBit   = strobe.chanB ? csRight[strobe.frameIdx] : csLeft[strobe.frameIdx];
    uBit   = userExtSel ? userPin
           : (strobe.chanB ? userRight[strobe.frameIdx] : userLeft[strobe.frameIdx]);
    parBit = ^{cBit, uBit, validIn, audio};
    newPay = {parBit, cBit, uBit, validIn, audio};
    if (strobe.chanB) newPat = PRE_W;
    else if (strobe.frameIdx == '0) newPat = PRE_B;
    else newPat = PRE_M;
  end

  // sample holding and slip detection
  assign dropEvt   = sampleStrobe && fresh && !strobe.frameStart;
  assign repeatEvt = strobe.frameStart && !fresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdL <= '0; holdR <= '0; txL <= '0; txR <= '0;
      fresh <= 1'b0; slipPulse <= 1'b0;
    end else begin
      slipPulse <= dropEvt || repeatEvt;
      if (strobe.frameStart && fresh) begin
        txL <= holdL;
        txR <= holdR;
      end
      if (sampleStrobe) begin
        holdL <= leftIn;
        holdR <= rightIn;
        fresh <= 1'b1;
      end else if (strobe.frameStart) begin
        fresh <= 1'b0;
      end
    end
  end

  // bi-phase mark encoder
  assign startNow = strobe.subStart ? lineLvl : startLvl;
  assign patNow   = strobe.subStart ? newPat : patReg;
  assign slotIdx  = strobe.subCell[SUBCELL_W-1:1];
  assign payIdx   = slotIdx - 5'd4;

  always_comb begin
    if (strobe.subCell < SUBCELL_W'(8))
      nextLvl = patNow[3'd7 - strobe.subCell[2:0]] ^ startNow;
    else if (!strobe.subCell[0])
      nextLvl = !lineLvl;
    else
      nextLvl = lineLvl ^ payload[payIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineLvl  <= 1'b0;
      startLvl <= 1'b0;
      patReg   <= '0;
      payload  <= '0;
    end else if (strobe.emit) begin
      lineLvl <= nextLvl;
      if (strobe.subStart) begin
        startLvl <= lineLvl;
        patReg   <= newPat;
        payload  <= newPay;
      end
    end
  end
endmodule

// File: rtl/aes3Tx.sv
module aes3Tx
  import aes3TxPkg::*;
#(
  parameter int SYNC_HOLD = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cellEn,
  input  logic                    txClkOk,
  input  logic                    sampleStrobe,
  input  logic [SAMPLE_W-1:0]     leftIn,
  input  logic [SAMPLE_W-1:0]     rightIn,
  input  logic                    validIn,
  input  logic [BLOCK_FRAMES-1:0] csLeft,
  input  logic [BLOCK_FRAMES-1:0] csRight,
  input  logic [BLOCK_FRAMES-1:0] userLeft,
  input  logic [BLOCK_FRAMES-1:0] userRight,
  input  logic                    userExtSel,
  input  logic                    userPin,
  input  logic                    mute,
  input  logic                    outDisable,
  input  logic                    syncIsInput,
  input  logic                    syncIn,
  output logic                    syncOut,
  output logic                    syncOe,
  output logic                    txP,
  output logic                    txN,
  output logic                    slipPulse
);
  txStrobe_t strobe;
  logic      lineLvl;
  logic      driveOn;

  aes3TxCtrl #(.SYNC_HOLD(SYNC_HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .cellEn(cellEn), .syncIsInput(syncIsInput),
    .syncIn(syncIn), .strobe(strobe), .syncOut(syncOut)
  );

  aes3TxPath u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleStrobe(sampleStrobe),
    .leftIn(leftIn), .rightIn(rightIn), .validIn(validIn),
    .csLeft(csLeft), .csRight(csRight), .userLeft(userLeft), .userRight(userRight),
    .userExtSel(userExtSel), .userPin(userPin), .mute(mute),
    .lineLvl(lineLvl), .slipPulse(slipPulse)
  );

  assign driveOn = rstN && txClkOk && !outDisable;
  assign txP     = driveOn && lineLvl;
  assign txN     = driveOn && !lineLvl;
  assign syncOe  = !syncIsInput;
endmodule

// File: rtl/aes3TxChk.sv
module aes3TxChk (
  input logic clk,
  input logic rstN,
  input logic cellEn,
  input logic txClkOk,
  input logic outDisable,
  input logic syncIsInput,
  input logic syncOut,
  input logic txP,
  input logic txN
);
  AST_DIFF_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txP && txN)); // R7

  AST_DIFF_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (txClkOk && !outDisable) |-> (txP != txN)); // R2

  AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !cellEn |=> (txP == $past(txP)) || (outDisable != $past(outDisable))
                || (txClkOk != $past(txClkOk))); // R2

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    syncIsInput |-> !syncOut); // R12

  AST_SYNCOUT_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(syncOut) && !syncIsInput) |=> (syncOut || syncIsInput)); // R12
endmodule

bind aes3Tx aes3TxChk u_chk (
  .clk(clk), .rstN(rstN), .cellEn(cellEn), .txClkOk(txClkOk),
  .outDisable(outDisable), .syncIsInput(syncIsInput), .syncOut(syncOut),
  .txP(txP), .txN(txN)
);

// File: tb/sim_aes3Tx.sv
module sim_aes3Tx;
  logic clk = 0;
  logic rstN = 0, cellEn = 0, txClkOk = 1, sampleStrobe = 0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic validIn = 0;
  logic [191:0] csLeft, csRight, userLeft, userRight;
  logic userExtSel = 0, userPin = 0, mute = 0, outDisable = 0;
  logic syncIsInput = 0, syncIn = 0;
  logic syncOut, syncOe, txP, txN, slipPulse;

  int checks = 0, errors = 0;
  int expSlips = 0, slipSeen = 0;
  int refCell = 0, refFrame = 0, sampleNo = 0;
  logic refLevel = 0, rStart = 0, rFresh = 0;
  logic [23:0] rHoldL = '0, rHoldR = '0, rTxL = '0, rTxR = '0;
  logic [27:0] rPay = '0;
  logic [7:0] rPat = '0;
  logic errFlag = 0, preFlag = 0;
  int badAct = 0, badExp = 0;
  string curTag = "R1 R2 R4 R8";

  always #10 clk = ~clk;

  aes3Tx u0 (.*);

  always @(negedge clk) if (rstN && slipPulse) slipSeen++;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] valL(input int n);
    return 24'(n * 24'h0B1F3 + 5);
  endfunction
  function automatic logic [23:0] valR(input int n);
    return 24'(n * 24'h3A05 + 24'h800001);
  endfunction

  task automatic cellStep(input logic doStrobe);
    int c, sc;
    logic cb, ub;
    logic [23:0] aud;
    c = refCell;
    sc = c % 64;
    @(negedge clk);
    cellEn = 1;
    sampleStrobe = doStrobe;
    if (doStrobe) begin
      leftIn = valL(sampleNo);
      rightIn = valR(sampleNo);
      sampleNo++;
    end
    userPin = refFrame[0] ^ c[6] ^ refFrame[2];
    if (sc == 0) begin
      if (c == 0) begin
        if (!rFresh) expSlips++;
        else begin rTxL = rHoldL; rTxR = rHoldR; end
      end
      aud = mute ? 24'd0 : ((c == 0) ? rTxL : rTxR);
      cb = (c == 0) ? csLeft[refFrame] : csRight[refFrame];
      ub = userExtSel ? userPin : ((c == 0) ? userLeft[refFrame] : userRight[refFrame]);
      rPay = {^{cb, ub, validIn, aud}, cb, ub, validIn, aud};
      rStart = refLevel;
      rPat = (c != 0) ? 8'b11100100 : ((refFrame == 0) ? 8'b11101000 : 8'b11100010);
      errFlag = 0;
      preFlag = 0;
    end
    if (doStrobe) begin
      if (rFresh && c != 0) expSlips++;
      rHoldL = leftIn;
      rHoldR = rightIn;
      rFresh = 1;
    end else if (c == 0) rFresh = 0;
    if (sc < 8) refLevel = rPat[7 - sc] ^ rStart;
    else if (sc % 2 == 0) refLevel = ~refLevel;
    else refLevel = refLevel ^ rPay[sc / 2 - 4];
    @(negedge clk);
    cellEn = 0;
    sampleStrobe = 0;
    begin
      logic en;
      logic eP, eN;
      en = txClkOk && !outDisable;
      eP = en && refLevel;
      eN = en && !refLevel;
      if (txP !== eP || txN !== eN) begin
        if (sc < 8) preFlag = 1; else errFlag = 1;
        badAct = {txP, txN};
        badExp = {eP, eN};
      end
    end
    if (sc == 7) check(!preFlag, "R3 preamble", badAct, badExp);
    if (sc == 63) check(!errFlag, curTag, badAct, badExp);
    if (!syncIsInput && c == 5)
      check(syncOut == (refFrame == 0) && syncOe, "R12 syncOut", syncOut, refFrame == 0);
    refCell = (c + 1) % 128;
    if (refCell == 0) refFrame = (refFrame + 1) % 192;
  endtask

  task automatic runFrame(input int strobeA, input int strobeB);
    for (int i = 0; i < 128; i++) cellStep(i == strobeA || i == strobeB);
  endtask

  task automatic holdSync(input int n);
    @(negedge clk); syncIn = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); syncIn = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    csLeft    = {6{32'h1234_5ABC}};
    csRight   = {6{32'hC0FF_EE17}};
    userLeft  = {6{32'hF0F0_3C3C}};
    userRight = {6{32'h0F5A_9968}};
    repeat (4) @(negedge clk);
    check(txP == 0 && txN == 0, "R7 reset", {txP, txN}, 0);
    check(slipPulse == 0, "R9 reset", slipPulse, 0);
    rstN = 1;
    @(negedge clk);
    check(syncOe == 1 && syncOut == 0, "R12 idle", {syncOe, syncOut}, 2);

    // normal run across a full block and its wrap
    validIn = 0;
    for (int f = 0; f < 194; f++) begin
      validIn = f[3];
      runFrame(64, -1);
    end
    check(slipSeen == expSlips, "R8 R9 slips normal", slipSeen, expSlips);

    // mute
    curTag = "R6 mute";
    mute = 1;
    repeat (3) runFrame(64, -1);
    mute = 0;

    // external user bits
    curTag = "R5 external user";
    userExtSel = 1;
    repeat (3) runFrame(64, -1);
    userExtSel = 0;

    // drops and repeats
    curTag = "R8 drop repeat";
    runFrame(40, 100);
    runFrame(-1, -1);
    runFrame(0, -1);
    runFrame(0, 70);
    check(slipSeen == expSlips, "R9 slip count", slipSeen, expSlips);

    // output disable and missing transmit clock
    curTag = "R7 disabled";
    outDisable = 1;
    for (int i = 0; i < 20; i++) cellStep(0);
    check(txP == 0 && txN == 0, "R7 outDisable", {txP, txN}, 0);
    outDisable = 0;
    txClkOk = 0;
    for (int i = 0; i < 20; i++) cellStep(0);
    check(txP == 0 && txN == 0, "R7 txClkOk", {txP, txN}, 0);
    txClkOk = 1;
    while (refCell != 0) cellStep(0);
    curTag = "R1 R2 after disable";
    runFrame(64, -1);

    // sync input: short pulse, boundary pulse, long pulse
    syncIsInput = 1;
    @(negedge clk);
    check(syncOe == 0 && syncOut == 0, "R12 input mode", {syncOe, syncOut}, 0);
    curTag = "R10 short sync";
    for (int i = 0; i < 40; i++) cellStep(i == 20);
    holdSync(3);
    while (refCell != 0) cellStep(refCell == 64);
    runFrame(64, -1);
    curTag = "R10 forced restart";
    for (int i = 0; i < 40; i++) cellStep(i == 10);
    holdSync(4);
    refCell = 0;
    refFrame = 0;
    runFrame(64, -1);
    runFrame(64, -1);
    curTag = "R11 long sync";
    for (int i = 0; i < 30; i++) cellStep(0);
    @(negedge clk); syncIn = 1;
    repeat (8) @(negedge clk);
    refCell = 0;
    refFrame = 0;
    for (int f = 0; f < 3; f++) runFrame(64, -1);
    syncIn = 0;
    repeat (4) @(negedge clk);
    runFrame(64, -1);
    check(slipSeen == expSlips, "R9 slips sync", slipSeen, expSlips);

    // back to output mode: frame 0 marking after wrap
    syncIsInput = 0;
    curTag = "R4 R12 second block";
    while (refFrame != 0) runFrame(64, -1);
    runFrame(64, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule